// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation-buffer miss by walking a two-level page table in memory. It takes the missing virtual page number and cuts it into an upper index, which selects a word in the directory, and a lower index, which selects a word in the second-level table that the directory word points to. Each lookup goes out as a single word read on a request/response memory port. The walker then either hands the final table entry back for a buffer refill or reports a page fault together with the level that stopped the walk.

Only one walk runs at a time. A `busy` output holds new start requests off from the cycle after a walk is accepted until the cycle after its completion or fault pulse. A fault leaves nothing behind: the entry output stays zero, and the walker is idle again one cycle later, so the faulting access can be retried once software has repaired the tables. The directory base is sampled when a walk starts. Pages are 4 KB, virtual addresses are 32 bits, and the two indices are 10 bits each by default.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted, and right after it is released, `busy`, `mem_req_valid`, `walk_done` and `walk_fault` are low and `walk_pte` and `fault_level` are zero.
- R2: A high `walk_req` starts a walk only when `busy` is low. `busy` goes high on the following cycle and stays high until the cycle after the `walk_done` or `walk_fault` pulse. While `busy` is high, `walk_req` and `walk_vpn` have no effect.
- R3: The first read address is the directory base plus 4 times vpn[19:10]. `mem_req_valid` and the address stay steady until a cycle with `mem_req_ready` high.
- R4: After a valid directory word, the second read address is the directory word with bits 11:0 cleared, plus 4 times vpn[9:0].
- R5: Any number of idle cycles may pass between a request being accepted and its response. A `mem_rsp_valid` that arrives while no read is outstanding is ignored.
- R6: If bit 0 of the directory word is 0, no second read is issued. `walk_fault` pulses for one cycle with `fault_level` = 0.
- R7: If bit 0 of the table word is 0, `walk_fault` pulses for one cycle with `fault_level` = 1.
- R8: If bit 0 of the table word is 1, `walk_done` pulses for one cycle and `walk_pte` carries the complete 32-bit table word. `walk_pte` is zero whenever `walk_done` is low, and `fault_level` is zero whenever `walk_fault` is low.
- R9: After a done or fault pulse, the walker takes a new `walk_req` on the very next cycle. A request held high without a break produces back-to-back walks.
- R10: The directory base is sampled when a walk is accepted. Changes to `dir_base` during a walk have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_req | input | 1 | Start a walk (taken only when not busy) |
| walk_vpn | input | 20 | Virtual page number to translate |
| dir_base | input | 32 | Directory base address |
| busy | output | 1 | Walk in progress; start requests are ignored |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| walk_done | output | 1 | One-cycle pulse: translation found |
| walk_pte | output | 32 | Final table word, non-zero only with walk_done |
| walk_fault | output | 1 | One-cycle pulse: page fault |
| fault_level | output | 1 | 0 = directory word invalid, 1 = table word invalid |

## Verification
The bench builds the walker with its default split: 12 offset bits and two 10-bit indices with 4-byte entries. This puts both indices at address bits 11:2 of their level and makes the index values 0 and 0x3FF reachable as the lowest and highest entries of a table. The memory model applies each latency from zero to several cycles and, in some runs, holds back ready at pseudo-random times. It also injects stray response pulses while no read is outstanding. These runs cover both fault levels, a start request and a base change during a walk, and an uninterrupted stream of back-to-back walks.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Walk sequencing; encodings are internal only.
  typedef enum logic [2:0] {
    WS_IDLE    = 3'd0,
    WS_DIR_REQ = 3'd1,
    WS_DIR_RSP = 3'd2,
    WS_PTE_REQ = 3'd3,
    WS_PTE_RSP = 3'd4,
    WS_HIT     = 3'd5,
    WS_MISS    = 3'd6
  } walk_state_e;

  localparam logic LVL_DIR = 1'b0;
  localparam logic LVL_PTE = 1'b1;

endpackage

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        req_ready_i,
  input  logic        rsp_valid_i,
  input  logic        entry_ok_i,
  output walk_state_e state_o,
  output logic        take_walk_o,
  output logic        take_tbl_o,
  output logic        take_pte_o,
  output logic        level_o
);

  walk_state_e st_q, st_d;
  logic        lvl_q, lvl_d;

  always_comb begin
    st_d        = st_q;
    lvl_d       = lvl_q;
    take_walk_o = 1'b0;
    take_tbl_o  = 1'b0;
    take_pte_o  = 1'b0;
    unique case (st_q)
      WS_IDLE: begin
        if (start_i) begin
          st_d        = WS_DIR_REQ;
          take_walk_o = 1'b1;
        end
      end
      WS_DIR_REQ: begin
        if (req_ready_i) st_d = WS_DIR_RSP;
      end
      WS_DIR_RSP: begin
        if (rsp_valid_i) begin
          if (entry_ok_i) begin
            st_d       = WS_PTE_REQ;
            take_tbl_o = 1'b1;
          end else begin
            st_d  = WS_MISS;
            lvl_d = LVL_DIR;
          end
        end
      end
      WS_PTE_REQ: begin
        if (req_ready_i) st_d = WS_PTE_RSP;
      end
      WS_PTE_RSP: begin
        if (rsp_valid_i) begin
          if (entry_ok_i) begin
            st_d       = WS_HIT;
            take_pte_o = 1'b1;
          end else begin
            st_d  = WS_MISS;
            lvl_d = LVL_PTE;
          end
        end
      end
      WS_HIT, WS_MISS: st_d = WS_IDLE;
      default:         st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WS_IDLE;
      lvl_q <= LVL_DIR;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
    end
  end

  assign state_o = st_q;
  assign level_o = lvl_q;

endmodule

// File: rtl/ptw_addr.sv
module ptw_addr #(
  parameter int VPN_W    = 20,
  parameter int DIR_BITS = 10,
  parameter int PA_W     = 32,
  parameter int ENT_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_walk_i,
  input  logic             take_tbl_i,
  input  logic             sel_tbl_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PA_W-1:0]  dir_base_i,
  input  logic [PA_W-1:0]  tbl_base_i,
  output logic [PA_W-1:0]  addr_o
);

  localparam int TBL_BITS = VPN_W - DIR_BITS;

  logic [VPN_W-1:0]    vpn_q;
  logic [PA_W-1:0]     dbase_q;
  logic [PA_W-1:0]     tbase_q;
  logic [DIR_BITS-1:0] d_idx;
  logic [TBL_BITS-1:0] t_idx;
  logic [PA_W-1:0]     d_addr;
  logic [PA_W-1:0]     t_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q   <= '0;
      dbase_q <= '0;
    end else if (take_walk_i) begin
      vpn_q   <= vpn_i;
      dbase_q <= dir_base_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbase_q <= '0;
    end else if (take_tbl_i) begin
      tbase_q <= tbl_base_i;
    end
  end

  assign d_idx  = vpn_q[VPN_W-1 -: DIR_BITS];
  assign t_idx  = vpn_q[TBL_BITS-1:0];
  assign d_addr = dbase_q + (PA_W'(d_idx) << ENT_LOG2);
  assign t_addr = tbase_q + (PA_W'(t_idx) << ENT_LOG2);
  assign addr_o = sel_tbl_i ? t_addr : d_addr;

endmodule

// File: rtl/ptw_entry.sv
module ptw_entry #(
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int VALID_POS = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_pte_i,
  input  logic [PA_W-1:0] rsp_data_i,
  output logic            entry_ok_o,
  output logic [PA_W-1:0] frame_base_o,
  output logic [PA_W-1:0] pte_o
);

  logic [PA_W-1:0] pte_q;

  assign entry_ok_o   = rsp_data_i[VALID_POS];
  assign frame_base_o = {rsp_data_i[PA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pte_q <= '0;
    end else if (take_pte_i) begin
      pte_q <= rsp_data_i;
    end
  end

  assign pte_o = pte_q;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int DIR_BITS  = 10,
  parameter int PA_W      = 32,
  parameter int ENT_LOG2  = 2,
  parameter int VALID_POS = 0,
  localparam int VPN_W    = VA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             walk_req,
  input  logic [VPN_W-1:0] walk_vpn,
  input  logic [PA_W-1:0]  dir_base,
  output logic             busy,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PA_W-1:0]  mem_rsp_data,
  output logic             walk_done,
  output logic [PA_W-1:0]  walk_pte,
  output logic             walk_fault,
  output logic             fault_level
);

  walk_state_e     state;
  logic            take_walk, take_tbl, take_pte, level;
  logic            entry_ok;
  logic [PA_W-1:0] frame_base;
  logic [PA_W-1:0] pte_q;

  ptw_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (walk_req),
    .req_ready_i (mem_req_ready),
    .rsp_valid_i (mem_rsp_valid),
    .entry_ok_i  (entry_ok),
    .state_o     (state),
    .take_walk_o (take_walk),
    .take_tbl_o  (take_tbl),
    .take_pte_o  (take_pte),
    .level_o     (level)
  );

  ptw_addr #(
    .VPN_W    (VPN_W),
    .DIR_BITS (DIR_BITS),
    .PA_W     (PA_W),
    .ENT_LOG2 (ENT_LOG2)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_walk_i (take_walk),
    .take_tbl_i  (take_tbl),
    .sel_tbl_i   (state == WS_PTE_REQ),
    .vpn_i       (walk_vpn),
    .dir_base_i  (dir_base),
    .tbl_base_i  (frame_base),
    .addr_o      (mem_req_addr)
  );

  ptw_entry #(
    .PA_W      (PA_W),
    .PAGE_BITS (PAGE_BITS),
    .VALID_POS (VALID_POS)
  ) u_entry (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_pte_i   (take_pte),
    .rsp_data_i   (mem_rsp_data),
    .entry_ok_o   (entry_ok),
    .frame_base_o (frame_base),
    .pte_o        (pte_q)
  );

  assign busy          = (state != WS_IDLE);
  assign mem_req_valid = (state == WS_DIR_REQ) || (state == WS_PTE_REQ);
  assign walk_done     = (state == WS_HIT);
  assign walk_fault    = (state == WS_MISS);
  assign walk_pte      = walk_done ? pte_q : '0;
  assign fault_level   = walk_fault & level;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int PA_W      = 32,
  parameter int VALID_POS = 0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            walk_req,
  input logic            busy,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic [PA_W-1:0] mem_rsp_data,
  input logic            walk_done,
  input logic [PA_W-1:0] walk_pte,
  input logic            walk_fault
);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && walk_req) |=> busy); // R2

  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3

  AST_DONE_PTE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> (walk_pte == $past(mem_rsp_data) && walk_pte[VALID_POS])); // R8

  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fault |-> ($past(mem_rsp_valid) && !$past(mem_rsp_data[VALID_POS]))); // R7

  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done || walk_fault) |=> !busy); // R9

endmodule

bind pt_walker ptw_checker #(
  .PA_W      (PA_W),
  .VALID_POS (VALID_POS)
) u_ptw_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .walk_req      (walk_req),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .walk_done     (walk_done),
  .walk_pte      (walk_pte),
  .walk_fault    (walk_fault)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_req = 1'b0;
  logic [19:0] walk_vpn = '0;
  logic [31:0] dir_base = '0;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        busy, mem_req_valid, walk_done, walk_fault, fault_level;
  logic [31:0] mem_req_addr, walk_pte;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk           (clk),
    .rst_n         (rst_n),
    .walk_req      (walk_req),
    .walk_vpn      (walk_vpn),
    .dir_base      (dir_base),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .walk_done     (walk_done),
    .walk_pte      (walk_pte),
    .walk_fault    (walk_fault),
    .fault_level   (fault_level)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    chk_en = 1'b0;
  string ctx = "R1 reset";

  // memory image of page tables
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic map_page(input logic [31:0] base, input logic [19:0] vpn,
                          input logic [19:0] frame, input logic [31:0] pte);
    mem[base + {20'h0, vpn[19:10], 2'b00}] = {frame, 12'h001};
    mem[{frame, 12'h000} + {20'h0, vpn[9:0], 2'b00}] = pte;
  endtask

  // behavioural reference: phase 0 idle,1 dir read,2 dir wait,3 tbl read,4 tbl wait,5 done,6 fault
  int          m_ph = 0;
  logic [19:0] m_vpn = '0;
  logic [31:0] m_base = '0, m_tb = '0, m_pte = '0;
  logic        m_lvl = 1'b0;
  int          m_dones = 0, m_faults = 0;
  int          req_cnt = 0, rsp_cnt = 0;
  logic [31:0] pend_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0;
    end else begin
      case (m_ph)
        0: if (walk_req) begin m_vpn = walk_vpn; m_base = dir_base; m_ph = 1; end
        1: if (mem_req_ready) begin
             pend_addr = m_base + {20'h0, m_vpn[19:10], 2'b00};
             req_cnt++; m_ph = 2;
           end
        2: if (mem_rsp_valid) begin
             if (mem_rsp_data[0]) begin m_tb = {mem_rsp_data[31:12], 12'h000}; m_ph = 3; end
             else begin m_lvl = 1'b0; m_ph = 6; m_faults++; end
           end
        3: if (mem_req_ready) begin
             pend_addr = m_tb + {20'h0, m_vpn[9:0], 2'b00};
             req_cnt++; m_ph = 4;
           end
        4: if (mem_rsp_valid) begin
             if (mem_rsp_data[0]) begin m_pte = mem_rsp_data; m_ph = 5; m_dones++; end
             else begin m_lvl = 1'b1; m_ph = 6; m_faults++; end
           end
        default: m_ph = 0;
      endcase
    end
  end

  // memory responder with latency, random ready and stray responses
  int         lat_cfg = 0;
  bit         rdy_rand = 1'b0;
  bit         spur = 1'b0;
  int         wait_cnt = 0;
  logic [7:0] lfsr = 8'hA5;

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready = rdy_rand ? lfsr[0] : 1'b1;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEAD_0000;
    if (req_cnt != rsp_cnt) begin
      if (wait_cnt >= lat_cfg) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(pend_addr);
        rsp_cnt++;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end else if (spur && lfsr[3]) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'hFFFF_F001;
    end
  end

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] act=%h exp=%h", req, ctx, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (chk_en) begin
      logic [31:0] e_addr;
      n_vec++;
      e_addr = (m_ph == 1) ? m_base + {20'h0, m_vpn[19:10], 2'b00}
                           : m_tb + {20'h0, m_vpn[9:0], 2'b00};
      cmp("R2 busy", {31'h0, busy}, {31'h0, m_ph != 0});
      cmp("R3 req_valid", {31'h0, mem_req_valid}, {31'h0, (m_ph == 1) || (m_ph == 3)});
      if (m_ph == 1) cmp("R3 dir addr", mem_req_addr, e_addr);
      if (m_ph == 3) cmp("R4 tbl addr", mem_req_addr, e_addr);
      cmp("R8 done", {31'h0, walk_done}, {31'h0, m_ph == 5});
      cmp("R8 pte", walk_pte, (m_ph == 5) ? m_pte : 32'h0);
      cmp(m_lvl ? "R7 fault" : "R6 fault", {31'h0, walk_fault}, {31'h0, m_ph == 6});
      cmp(m_lvl ? "R7 level" : "R6 level", {31'h0, fault_level}, {31'h0, (m_ph == 6) && m_lvl});
    end
  end

  // watchdog
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog [%s] act=%0d exp=<100000", ctx, cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic run_walk(input logic [19:0] vpn, input logic [31:0] base);
    @(negedge clk);
    walk_req = 1'b1; walk_vpn = vpn; dir_base = base;
    @(negedge clk);
    walk_req = 1'b0;
    while (m_ph != 0) @(negedge clk);
  endtask

  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [19:0] VA_A = {10'h003, 10'h155};
  localparam logic [19:0] VA_B = {10'h200, 10'h001};
  localparam logic [19:0] VA_C = {10'h010, 10'h020};
  localparam logic [19:0] VA_D = {10'h011, 10'h3FF};
  localparam logic [19:0] VA_E = 20'hFFFFF;
  localparam logic [19:0] VA_F = 20'h00000;

  initial begin
    map_page(BASE, VA_A, 20'h00023, 32'hABCD_E00F);
    map_page(BASE, VA_B, 20'h00040, 32'h1234_5001);
    map_page(BASE, VA_D, 20'h00050, 32'h7777_7006);
    map_page(BASE, VA_E, 20'h00060, 32'h0BEE_F003);
    map_page(BASE, VA_F, 20'h00070, 32'h0000_1001);

    // R1: outputs quiet during reset
    repeat (3) begin
      @(negedge clk);
      n_vec++;
      cmp("R1 reset", {27'h0, busy, mem_req_valid, walk_done, walk_fault, fault_level}, 32'h0);
      cmp("R1 reset pte", walk_pte, 32'h0);
    end
    rst_n = 1'b1;
    chk_en = 1'b1;
    repeat (2) @(negedge clk);

    ctx = "R3 R4 R8 basic";
    run_walk(VA_A, BASE);
    run_walk(VA_B, BASE);

    ctx = "R5 latency and ready stalls";
    lat_cfg = 4; rdy_rand = 1'b1;
    run_walk(VA_A, BASE);
    run_walk(VA_B, BASE);
    lat_cfg = 1;
    run_walk(VA_E, BASE);

    ctx = "R6 directory invalid";
    lat_cfg = 0; rdy_rand = 1'b0;
    run_walk(VA_C, BASE);
    lat_cfg = 3;
    run_walk(VA_C, BASE);

    ctx = "R7 table invalid";
    run_walk(VA_D, BASE);
    lat_cfg = 0;
    run_walk(VA_D, BASE);

    ctx = "R3 R4 index corners";
    run_walk(VA_E, BASE);
    run_walk(VA_F, BASE);

    ctx = "R5 stray responses";
    spur = 1'b1; rdy_rand = 1'b1; lat_cfg = 2;
    run_walk(VA_A, BASE);
    run_walk(VA_D, BASE);
    run_walk(VA_C, BASE);
    repeat (10) @(negedge clk);
    spur = 1'b0; rdy_rand = 1'b0;

    ctx = "R2 R10 busy ignores start and base";
    lat_cfg = 3;
    @(negedge clk);
    walk_req = 1'b1; walk_vpn = VA_B; dir_base = BASE;
    @(negedge clk);
    while (m_ph != 0) begin
      walk_vpn = VA_C; dir_base = 32'h0009_0000;
      walk_req = (m_ph != 5) && (m_ph != 6);
      @(negedge clk);
    end
    walk_req = 1'b0;
    repeat (2) @(negedge clk);

    ctx = "R9 back-to-back";
    lat_cfg = 0;
    begin
      int goal;
      goal = m_dones + 3;
      @(negedge clk);
      walk_req = 1'b1; walk_vpn = VA_A; dir_base = BASE;
      while (m_dones < goal) @(negedge clk);
      walk_req = 1'b0;
      while (m_ph != 0) @(negedge clk);
    end
    @(negedge clk);
    walk_req = 1'b1; walk_vpn = VA_C;
    @(negedge clk);
    walk_req = 1'b0;
    while (m_ph != 0) @(negedge clk);
    run_walk(VA_F, BASE);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule